// File: doc/BRIEF.md
# RV64 Subset Single-Cycle Core

This block is a single-cycle processor for a narrow slice of the 64-bit RISC-V base integer set. It runs thirteen instructions: add, sub, srl, sra, addi, xori, srli, srai, ld, sd, bne, auipc and jal. Each instruction is fetched, decoded, executed and written back in one clock. The wrapper holds a word-wide instruction ROM, a doubleword-wide data RAM, a 32 x 64-bit register file and the program counter. The ROM is filled through a write port. Final architectural state is read back through two combinational inspection ports.

A two-state controller gates execution. In `ST_IDLE` the PC is frozen and nothing is written. In `ST_EXEC` one instruction retires per cycle. The transition `IDLE->EXEC` is taken when `run` is high, and `EXEC->IDLE` is taken when `run` is low. Both states hold themselves otherwise.

Each retiring instruction is reported on a set of commit outputs: its PC, the next PC, any register write and any store.

Top module: `rv64s_core_top`

## Requirements
- R1: Reset sets the PC to 0, clears every register and data doubleword, and leaves the controller in `ST_IDLE` with `cmt_valid` low. The first instruction to retire after `run` rises is the one at address 0, and exactly one instruction retires per cycle spent in `ST_EXEC`.
- R2: Register 0 always reads as zero. An instruction whose destination is register 0 reports `cmt_rd_we` low and changes no state.
- R3: Opcode 0110011 performs register-register operations. With funct3 000, funct7 0000000 selects add and funct7 0100000 selects sub. With funct3 101, funct7 0000000 selects a logical right shift and funct7 0100000 selects an arithmetic right shift, both by R[rs2][5:0]. Any other funct3/funct7 pair is a no-op.
- R4: Opcode 0010011 uses the immediate in bits [31:20], sign-extended from 12 bits (0xFF8 becomes 0xFFFF_FFFF_FFFF_FFF8). funct3 000 selects addi and funct3 100 selects xori. funct3 101 shifts right by bits [25:20]. For that shift, bits [31:26] of 000000 select the logical form and 010000 select the arithmetic form.
- R5: Opcode 0000011 with funct3 011 loads rd with the 64-bit doubleword at byte address R[rs1]+sext(bits[31:20]). The RAM is indexed by address bits [7:3], so consecutive doublewords lie 8 bytes apart.
- R6: Opcode 0100011 with funct3 011 stores R[rs2] to byte address R[rs1]+sext({bits[31:25],bits[11:7]}). A store writes no register.
- R7: Opcode 1100011 with funct3 001 sets the next PC to PC+sext({b31,b7,b30:25,b11:8,0}) when R[rs1] differs from R[rs2], and to PC+4 otherwise. Every other instruction in `ST_EXEC` retires at the previous next PC.
- R8: Opcode 1101111 writes PC+4 to rd and sets the next PC to PC+sext({b31,b19:12,b20,b30:21,0}). Negative offsets are included.
- R9: Opcode 0010111 writes PC+sext({bits[31:12],12'b0}) to rd.
- R10: Any unrecognised opcode, or an unsupported funct3 under a known opcode, writes nothing and advances the PC by 4.
- R11: While `run` is low, the controller sits in `ST_IDLE`, the PC holds its value and `cmt_valid` is low. Raising `run` again resumes at the held PC.
- R12: `dbg_reg_val` returns register `dbg_reg_idx` and `dbg_mem_val` returns doubleword `dbg_mem_idx`, both combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Execute enable for the controller |
| imem_we | input | 1 | Instruction ROM write strobe |
| imem_addr | input | IAW | Instruction ROM word index |
| imem_wdata | input | 32 | Instruction word to write |
| dbg_reg_idx | input | 5 | Register inspection index |
| dbg_reg_val | output | XLEN | Register inspection value |
| dbg_mem_idx | input | DAW | Data RAM inspection doubleword index |
| dbg_mem_val | output | XLEN | Data RAM inspection value |
| cmt_valid | output | 1 | An instruction retires this cycle |
| cmt_pc | output | XLEN | Current PC |
| cmt_next_pc | output | XLEN | PC of the next instruction |
| cmt_rd_we | output | 1 | Retiring instruction writes a register |
| cmt_rd | output | 5 | Destination register |
| cmt_rd_val | output | XLEN | Value written to the destination |
| cmt_st_we | output | 1 | Retiring instruction stores |
| cmt_st_addr | output | XLEN | Store byte address |
| cmt_st_val | output | XLEN | Store data |

## Verification
A wrong register or RAM word stays hidden until an instruction reads it. From that cycle on, `cmt_rd_val`, `cmt_st_val` or the branch outcome in `cmt_next_pc` differs from the model's, usually at the very next dependent instruction. A wrong PC or immediate shows on the same retirement as a mismatching `cmt_pc` or `cmt_next_pc`. A controller stuck in the wrong state shows as commits appearing while `run` is low, or missing while it is high. The run-length count exposes that within one cycle.

// File: rtl/rv64s_pkg.sv
package rv64s_pkg;

    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_IMM    = 7'b0010011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_EXEC
    } core_state_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SRL,
        ALU_SRA,
        ALU_XOR
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_ALU,
        WB_MEM,
        WB_LINK
    } wb_sel_e;

    typedef struct packed {
        logic    rd_we;
        logic    mem_we;
        logic    is_bne;
        logic    is_jal;
        logic    a_is_pc;
        logic    b_is_imm;
        alu_op_e alu_op;
        wb_sel_e wb_sel;
    } ctrl_t;

endpackage

// File: rtl/rv64s_decode.sv
module rv64s_decode
    import rv64s_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:0]      instr,
    output logic [4:0]       rd,
    output logic [4:0]       rs1,
    output logic [4:0]       rs2,
    output logic [XLEN-1:0]  imm,
    output ctrl_t            ctrl
);

    logic [6:0]      opc;
    logic [2:0]      f3;
    logic [6:0]      f7;
    logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;
    logic            wr;

    assign opc = instr[6:0];
    assign rd  = instr[11:7];
    assign f3  = instr[14:12];
    assign rs1 = instr[19:15];
    assign rs2 = instr[24:20];
    assign f7  = instr[31:25];

    assign imm_i = {{(XLEN-12){instr[31]}}, instr[31:20]};
    assign imm_s = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
    assign imm_b = {{(XLEN-13){instr[31]}}, instr[31], instr[7],
                    instr[30:25], instr[11:8], 1'b0};
    assign imm_u = {{(XLEN-32){instr[31]}}, instr[31:12], 12'b0};
    assign imm_j = {{(XLEN-21){instr[31]}}, instr[31], instr[19:12],
                    instr[20], instr[30:21], 1'b0};

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        ctrl.wb_sel = WB_ALU;
        imm         = '0;
        wr          = 1'b0;
        case (opc)
            OPC_REG: begin
                if (f3 == 3'b000 && f7 == 7'b0000000) begin
                    wr = 1'b1; ctrl.alu_op = ALU_ADD;
                end else if (f3 == 3'b000 && f7 == 7'b0100000) begin
                    wr = 1'b1; ctrl.alu_op = ALU_SUB;
                end else if (f3 == 3'b101 && f7 == 7'b0000000) begin
                    wr = 1'b1; ctrl.alu_op = ALU_SRL;
                end else if (f3 == 3'b101 && f7 == 7'b0100000) begin
                    wr = 1'b1; ctrl.alu_op = ALU_SRA;
                end
            end
            OPC_IMM: begin
                imm           = imm_i;
                ctrl.b_is_imm = 1'b1;
                if (f3 == 3'b000) begin
                    wr = 1'b1; ctrl.alu_op = ALU_ADD;
                end else if (f3 == 3'b100) begin
                    wr = 1'b1; ctrl.alu_op = ALU_XOR;
                end else if (f3 == 3'b101 && instr[31:26] == 6'b000000) begin
                    wr = 1'b1; ctrl.alu_op = ALU_SRL;
                end else if (f3 == 3'b101 && instr[31:26] == 6'b010000) begin
                    wr = 1'b1; ctrl.alu_op = ALU_SRA;
                end
            end
            OPC_LOAD: begin
                if (f3 == 3'b011) begin
                    imm           = imm_i;
                    ctrl.b_is_imm = 1'b1;
                    ctrl.wb_sel   = WB_MEM;
                    wr            = 1'b1;
                end
            end
            OPC_STORE: begin
                if (f3 == 3'b011) begin
                    imm           = imm_s;
                    ctrl.b_is_imm = 1'b1;
                    ctrl.mem_we   = 1'b1;
                end
            end
            OPC_BRANCH: begin
                if (f3 == 3'b001) begin
                    imm         = imm_b;
                    ctrl.is_bne = 1'b1;
                end
            end
            OPC_AUIPC: begin
                imm           = imm_u;
                ctrl.a_is_pc  = 1'b1;
                ctrl.b_is_imm = 1'b1;
                wr            = 1'b1;
            end
            OPC_JAL: begin
                imm         = imm_j;
                ctrl.is_jal = 1'b1;
                ctrl.wb_sel = WB_LINK;
                wr          = 1'b1;
            end
            default: ;
        endcase
        ctrl.rd_we = wr && (rd != 5'd0);
    end

endmodule

// File: rtl/rv64s_alu.sv
module rv64s_alu
    import rv64s_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y
);

    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] shamt;
    assign shamt = b[SHW-1:0];

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SRL: y = a >> shamt;
            ALU_SRA: y = $signed(a) >>> shamt;
            ALU_XOR: y = a ^ b;
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/rv64s_regfile.sv
module rv64s_regfile #(
    parameter int XLEN  = 64,
    parameter int NREGS = 32,
    localparam int RAW  = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [RAW-1:0]  wa,
    input  logic [XLEN-1:0] wd,
    input  logic [RAW-1:0]  ra1,
    input  logic [RAW-1:0]  ra2,
    input  logic [RAW-1:0]  ra3,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    output logic [XLEN-1:0] rd3
);

    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

endmodule

// File: rtl/rv64s_core_top.sv
module rv64s_core_top
    import rv64s_pkg::*;
#(
    parameter int  IMEM_WORDS  = 64,
    parameter int  DMEM_DWORDS = 32,
    parameter int  XLEN        = 64,
    localparam int IAW         = $clog2(IMEM_WORDS),
    localparam int DAW         = $clog2(DMEM_DWORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            imem_we,
    input  logic [IAW-1:0]  imem_addr,
    input  logic [31:0]     imem_wdata,
    input  logic [4:0]      dbg_reg_idx,
    output logic [XLEN-1:0] dbg_reg_val,
    input  logic [DAW-1:0]  dbg_mem_idx,
    output logic [XLEN-1:0] dbg_mem_val,
    output logic            cmt_valid,
    output logic [XLEN-1:0] cmt_pc,
    output logic [XLEN-1:0] cmt_next_pc,
    output logic            cmt_rd_we,
    output logic [4:0]      cmt_rd,
    output logic [XLEN-1:0] cmt_rd_val,
    output logic            cmt_st_we,
    output logic [XLEN-1:0] cmt_st_addr,
    output logic [XLEN-1:0] cmt_st_val
);

    core_state_e     state_q, state_d;
    logic            exec;
    logic [XLEN-1:0] pc_q, pc_next, pc_plus4;
    logic [31:0]     instr;
    logic [4:0]      rd, rs1, rs2;
    logic [XLEN-1:0] imm, rs1_v, rs2_v, alu_a, alu_b, alu_y, ld_v, wb_v;
    ctrl_t           ctrl;

    logic [31:0]     imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_DWORDS];

    // Controller: state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Controller: transitions
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = run ? ST_EXEC : ST_IDLE;
            ST_EXEC: state_d = run ? ST_EXEC : ST_IDLE;
        endcase
    end

    // Controller: outputs
    always_comb begin
        exec        = (state_q == ST_EXEC);
        cmt_valid   = exec;
        cmt_pc      = pc_q;
        cmt_next_pc = pc_next;
        cmt_rd_we   = exec && ctrl.rd_we;
        cmt_rd      = rd;
        cmt_rd_val  = wb_v;
        cmt_st_we   = exec && ctrl.mem_we;
        cmt_st_addr = alu_y;
        cmt_st_val  = rs2_v;
    end

    // Instruction ROM
    always_ff @(posedge clk) begin
        if (imem_we) imem[imem_addr] <= imem_wdata;
    end
    assign instr = imem[pc_q[2 +: IAW]];

    rv64s_decode #(.XLEN(XLEN)) u_dec (
        .instr (instr),
        .rd    (rd),
        .rs1   (rs1),
        .rs2   (rs2),
        .imm   (imm),
        .ctrl  (ctrl)
    );

    rv64s_regfile #(.XLEN(XLEN), .NREGS(32)) u_rf (
        .clk (clk),
        .rst (rst),
        .we  (cmt_rd_we),
        .wa  (rd),
        .wd  (wb_v),
        .ra1 (rs1),
        .ra2 (rs2),
        .ra3 (dbg_reg_idx),
        .rd1 (rs1_v),
        .rd2 (rs2_v),
        .rd3 (dbg_reg_val)
    );

    assign alu_a = ctrl.a_is_pc  ? pc_q : rs1_v;
    assign alu_b = ctrl.b_is_imm ? imm  : rs2_v;

    rv64s_alu #(.XLEN(XLEN)) u_alu (
        .a  (alu_a),
        .b  (alu_b),
        .op (ctrl.alu_op),
        .y  (alu_y)
    );

    // Data RAM, doubleword granular
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DMEM_DWORDS; i++) dmem[i] <= '0;
        end else if (cmt_st_we) begin
            dmem[alu_y[3 +: DAW]] <= rs2_v;
        end
    end
    assign ld_v        = dmem[alu_y[3 +: DAW]];
    assign dbg_mem_val = dmem[dbg_mem_idx];

    // Write-back and next PC
    assign pc_plus4 = pc_q + XLEN'(4);

    always_comb begin
        unique case (ctrl.wb_sel)
            WB_MEM:  wb_v = ld_v;
            WB_LINK: wb_v = pc_plus4;
            default: wb_v = alu_y;
        endcase
        if (ctrl.is_jal)                          pc_next = pc_q + imm;
        else if (ctrl.is_bne && rs1_v != rs2_v)   pc_next = pc_q + imm;
        else                                      pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst)       pc_q <= '0;
        else if (exec) pc_q <= pc_next;
    end

endmodule

// File: rtl/rv64s_core_checker.sv
module rv64s_core_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic [4:0]      dbg_reg_idx,
    input logic [XLEN-1:0] dbg_reg_val,
    input logic            cmt_valid,
    input logic [XLEN-1:0] cmt_pc,
    input logic [XLEN-1:0] cmt_next_pc,
    input logic            cmt_rd_we,
    input logic [4:0]      cmt_rd,
    input logic            cmt_st_we
);

    AST_IDLE_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmt_valid |=> (cmt_pc == $past(cmt_pc)));                         // R11

    AST_PC_CHAIN: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && $past(cmt_valid)) |-> (cmt_pc == $past(cmt_next_pc))); // R7

    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (rst)
        (dbg_reg_idx == 5'd0) |-> (dbg_reg_val == '0));                    // R2

    AST_ZERO_REG_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        cmt_rd_we |-> (cmt_rd != 5'd0));                                   // R2

    AST_STORE_NO_RD: assert property (@(posedge clk) disable iff (rst)
        cmt_st_we |-> !cmt_rd_we);                                          // R6

    AST_NO_COMMIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cmt_valid |-> (!cmt_rd_we && !cmt_st_we));                         // R11

    AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        cmt_valid |-> (cmt_next_pc[0] == 1'b0));                            // R8

endmodule

bind rv64s_core_top rv64s_core_checker #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dbg_reg_idx (dbg_reg_idx),
    .dbg_reg_val (dbg_reg_val),
    .cmt_valid   (cmt_valid),
    .cmt_pc      (cmt_pc),
    .cmt_next_pc (cmt_next_pc),
    .cmt_rd_we   (cmt_rd_we),
    .cmt_rd      (cmt_rd),
    .cmt_st_we   (cmt_st_we)
);

// File: tb/rv64s_core_top_test.sv
module rv64s_core_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_addr = '0;
    logic [31:0] imem_wdata = '0;
    logic [4:0]  dbg_reg_idx = '0;
    logic [63:0] dbg_reg_val;
    logic [4:0]  dbg_mem_idx = '0;
    logic [63:0] dbg_mem_val;
    logic        cmt_valid;
    logic [63:0] cmt_pc, cmt_next_pc, cmt_rd_val, cmt_st_addr, cmt_st_val;
    logic        cmt_rd_we, cmt_st_we;
    logic [4:0]  cmt_rd;

    always #5 clk = ~clk;

    rv64s_core_top uut (
        .clk(clk), .rst(rst), .run(run),
        .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
        .dbg_reg_idx(dbg_reg_idx), .dbg_reg_val(dbg_reg_val),
        .dbg_mem_idx(dbg_mem_idx), .dbg_mem_val(dbg_mem_val),
        .cmt_valid(cmt_valid), .cmt_pc(cmt_pc), .cmt_next_pc(cmt_next_pc),
        .cmt_rd_we(cmt_rd_we), .cmt_rd(cmt_rd), .cmt_rd_val(cmt_rd_val),
        .cmt_st_we(cmt_st_we), .cmt_st_addr(cmt_st_addr), .cmt_st_val(cmt_st_val)
    );

    typedef struct {
        logic [63:0] pc;
        logic [63:0] next_pc;
        logic        rd_we;
        logic [4:0]  rd;
        logic [63:0] rd_val;
        logic        st_we;
        logic [63:0] st_addr;
        logic [63:0] st_val;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    logic [31:0] ref_imem [64];
    logic [63:0] ref_x [32];
    logic [63:0] ref_m [32];
    logic [63:0] ref_pc;

    localparam logic [6:0] O_R = 7'b0110011, O_I = 7'b0010011, O_LD = 7'b0000011,
                           O_SD = 7'b0100011, O_B = 7'b1100011, O_AU = 7'b0010111,
                           O_J = 7'b1101111;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Encoders
    function automatic logic [31:0] e_r(logic [6:0] f7, logic [4:0] b, logic [4:0] a,
                                        logic [2:0] f3, logic [4:0] d);
        return {f7, b, a, f3, d, O_R};
    endfunction
    function automatic logic [31:0] e_i(logic [11:0] im, logic [4:0] a, logic [2:0] f3,
                                        logic [4:0] d);
        return {im, a, f3, d, O_I};
    endfunction
    function automatic logic [31:0] e_s(logic [11:0] im, logic [4:0] b, logic [4:0] a);
        return {im[11:5], b, a, 3'b011, im[4:0], O_SD};
    endfunction
    function automatic logic [31:0] e_b(logic [12:0] im, logic [4:0] b, logic [4:0] a);
        return {im[12], im[10:5], b, a, 3'b001, im[4:1], im[11], O_B};
    endfunction
    function automatic logic [31:0] e_u(logic [19:0] im, logic [4:0] d);
        return {im, d, O_AU};
    endfunction
    function automatic logic [31:0] e_j(logic [20:0] im, logic [4:0] d);
        return {im[20], im[10:1], im[11], im[19:12], d, O_J};
    endfunction

    // Reference model: one instruction
    task automatic ref_step();
        exp_t        e;
        logic [31:0] w;
        logic [6:0]  op, f7;
        logic [2:0]  f3;
        logic [4:0]  rd, a, b;
        logic [63:0] va, vb, ii, is, ib, iu, ij;
        w  = ref_imem[ref_pc[7:2]];
        op = w[6:0]; rd = w[11:7]; f3 = w[14:12]; a = w[19:15]; b = w[24:20]; f7 = w[31:25];
        va = ref_x[a]; vb = ref_x[b];
        ii = {{52{w[31]}}, w[31:20]};
        is = {{52{w[31]}}, w[31:25], w[11:7]};
        ib = {{51{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
        iu = {{32{w[31]}}, w[31:12], 12'b0};
        ij = {{43{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
        e.pc = ref_pc; e.next_pc = ref_pc + 64'd4; e.rd_we = 1'b0; e.rd = rd;
        e.rd_val = '0; e.st_we = 1'b0; e.st_addr = '0; e.st_val = '0; e.tag = "R10";
        case (op)
            O_R: begin
                e.tag = "R3";
                if (f3 == 3'b000 && f7 == 7'h00)      begin e.rd_we = 1; e.rd_val = va + vb; end
                else if (f3 == 3'b000 && f7 == 7'h20) begin e.rd_we = 1; e.rd_val = va - vb; end
                else if (f3 == 3'b101 && f7 == 7'h00) begin e.rd_we = 1; e.rd_val = va >> vb[5:0]; end
                else if (f3 == 3'b101 && f7 == 7'h20) begin e.rd_we = 1; e.rd_val = $signed(va) >>> vb[5:0]; end
                else e.tag = "R10";
            end
            O_I: begin
                e.tag = "R4";
                if (f3 == 3'b000)      begin e.rd_we = 1; e.rd_val = va + ii; end
                else if (f3 == 3'b100) begin e.rd_we = 1; e.rd_val = va ^ ii; end
                else if (f3 == 3'b101 && w[31:26] == 6'b000000) begin e.rd_we = 1; e.rd_val = va >> w[25:20]; end
                else if (f3 == 3'b101 && w[31:26] == 6'b010000) begin e.rd_we = 1; e.rd_val = $signed(va) >>> w[25:20]; end
                else e.tag = "R10";
            end
            O_LD: if (f3 == 3'b011) begin
                e.tag = "R5"; e.rd_we = 1; e.rd_val = ref_m[(va + ii) >> 3];
            end
            O_SD: if (f3 == 3'b011) begin
                e.tag = "R6"; e.st_we = 1; e.st_addr = va + is; e.st_val = vb;
            end
            O_B: if (f3 == 3'b001) begin
                e.tag = "R7";
                if (va != vb) e.next_pc = ref_pc + ib;
            end
            O_AU: begin e.tag = "R9"; e.rd_we = 1; e.rd_val = ref_pc + iu; end
            O_J:  begin e.tag = "R8"; e.rd_we = 1; e.rd_val = ref_pc + 64'd4; e.next_pc = ref_pc + ij; end
            default: ;
        endcase
        if (e.rd_we && rd == 5'd0) begin e.rd_we = 1'b0; e.tag = "R2"; end
        if (e.rd_we) ref_x[rd] = e.rd_val;
        if (e.st_we) ref_m[e.st_addr[7:3]] = e.st_val;
        ref_pc = e.next_pc;
        exp_q.push_back(e);
    endtask

    // Monitor: pops expected retirements as the design produces them
    always @(negedge clk) begin
        if (!rst && cmt_valid && !done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1", "unexpected retirement pc", cmt_pc, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(cmt_pc == e.pc, e.tag, "pc", cmt_pc, e.pc);
                chk(cmt_next_pc == e.next_pc, e.tag, "next pc", cmt_next_pc, e.next_pc);
                chk(cmt_rd_we == e.rd_we, e.tag, "rd write enable", 64'(cmt_rd_we), 64'(e.rd_we));
                if (e.rd_we) begin
                    chk(cmt_rd == e.rd, e.tag, "rd index", 64'(cmt_rd), 64'(e.rd));
                    chk(cmt_rd_val == e.rd_val, e.tag, "rd value", cmt_rd_val, e.rd_val);
                end
                chk(cmt_st_we == e.st_we, e.tag, "store enable", 64'(cmt_st_we), 64'(e.st_we));
                if (e.st_we) begin
                    chk(cmt_st_addr == e.st_addr, e.tag, "store address", cmt_st_addr, e.st_addr);
                    chk(cmt_st_val == e.st_val, e.tag, "store data", cmt_st_val, e.st_val);
                end
            end
        end
    end

    // Driver: loads a program, queues its expected retirements, runs it
    task automatic run_prog(input int n1, input int gap, input int n2);
        logic [63:0] held;
        rst = 1'b1; run = 1'b0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            imem_we = 1'b1; imem_addr = 6'(i); imem_wdata = ref_imem[i];
        end
        @(negedge clk);
        imem_we = 1'b0;
        for (int i = 0; i < 32; i++) begin ref_x[i] = '0; ref_m[i] = '0; end
        ref_pc = '0;
        for (int i = 0; i < n1 + n2; i++) ref_step();
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(cmt_valid == 1'b0, "R1", "valid after reset", 64'(cmt_valid), 64'd0);
        chk(cmt_pc == 64'd0, "R1", "pc after reset", cmt_pc, 64'd0);
        @(negedge clk);
        run = 1'b1;
        repeat (n1) @(negedge clk);
        run = 1'b0;
        if (gap > 0) begin
            @(negedge clk);
            held = cmt_pc;
            chk(cmt_valid == 1'b0, "R11", "valid while run low", 64'(cmt_valid), 64'd0);
            for (int g = 1; g < gap; g++) begin
                @(negedge clk);
                chk(cmt_valid == 1'b0, "R11", "valid while run low", 64'(cmt_valid), 64'd0);
                chk(cmt_pc == held, "R11", "pc held while idle", cmt_pc, held);
            end
        end
        if (n2 > 0) begin
            run = 1'b1;
            repeat (n2) @(negedge clk);
            run = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R1", "retirements still pending", 64'(exp_q.size()), 64'd0);
        for (int r = 0; r < 32; r++) begin
            dbg_reg_idx = 5'(r);
            #1;
            chk(dbg_reg_val == ref_x[r], (r == 0) ? "R2" : "R12", "final register", dbg_reg_val, ref_x[r]);
        end
        for (int m = 0; m < 32; m++) begin
            dbg_mem_idx = 5'(m);
            #1;
            chk(dbg_mem_val == ref_m[m], "R12", "final doubleword", dbg_mem_val, ref_m[m]);
        end
        exp_q.delete();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired cycle", 64'd100000, 64'd0);
        finish_up();
    end

    initial begin
        // Program A: arithmetic, shifts, memory, x0
        for (int i = 0; i < 64; i++) ref_imem[i] = 32'h0000006F;
        ref_imem[0]  = e_i(12'd100, 5'd0, 3'b000, 5'd6);        // R4 addi x6
        ref_imem[1]  = e_i(12'hFF8, 5'd0, 3'b000, 5'd2);        // R4 sign extension
        ref_imem[2]  = 32'h002302B3;                            // R3 add x5,x6,x2
        ref_imem[3]  = e_r(7'h20, 5'd2, 5'd5, 3'b000, 5'd3);    // R3 sub
        ref_imem[4]  = e_i(12'd16, 5'd0, 3'b000, 5'd22);
        ref_imem[5]  = e_s(12'd64, 5'd5, 5'd22);                // R6 store
        ref_imem[6]  = 32'h040B3483;                            // R5 ld x9,64(x22)
        ref_imem[7]  = e_i(12'd1, 5'd9, 3'b000, 5'd9);
        ref_imem[8]  = 32'h0E953823;                            // R6 sd x9,240(x10)
        ref_imem[9]  = e_i(12'h555, 5'd2, 3'b100, 5'd7);        // R4 xori
        ref_imem[10] = e_i(12'd61, 5'd0, 3'b000, 5'd1);
        ref_imem[11] = e_r(7'h00, 5'd1, 5'd2, 3'b101, 5'd8);    // R3 srl
        ref_imem[12] = e_r(7'h20, 5'd1, 5'd2, 3'b101, 5'd12);   // R3 sra
        ref_imem[13] = e_i(12'd60, 5'd2, 3'b101, 5'd13);        // R4 srli
        ref_imem[14] = e_i(12'h403, 5'd2, 3'b101, 5'd14);       // R4 srai
        ref_imem[15] = e_i(12'h402, 5'd6, 3'b101, 5'd15);       // R4 srai positive
        ref_imem[16] = e_i(12'd5, 5'd0, 3'b000, 5'd0);          // R2 write to x0
        ref_imem[17] = e_r(7'h00, 5'd9, 5'd0, 3'b000, 5'd16);   // R2 read of x0
        ref_imem[18] = 32'h0000007F;                            // R10 unknown opcode
        ref_imem[19] = e_r(7'h00, 5'd2, 5'd6, 3'b001, 5'd17);   // R10 unsupported funct3
        ref_imem[20] = e_i(12'd1, 5'd7, 3'b010, 5'd18);         // R10 unsupported imm op
        run_prog(12, 3, 14);

        // Program B: branches, jumps, upper immediates
        for (int i = 0; i < 64; i++) ref_imem[i] = 32'h0000006F;
        ref_imem[0]  = e_i(12'd3, 5'd0, 3'b000, 5'd1);
        ref_imem[1]  = e_i(12'hFFF, 5'd1, 3'b000, 5'd1);
        ref_imem[2]  = e_b(13'h1FFC, 5'd0, 5'd1);               // R7 backward taken
        ref_imem[3]  = e_b(13'd8, 5'd0, 5'd1);                  // R7 not taken
        ref_imem[4]  = e_j(21'd8, 5'd11);                       // R8 forward link
        ref_imem[5]  = e_i(12'd99, 5'd0, 3'b000, 5'd20);
        ref_imem[6]  = e_u(20'h12345, 5'd13);                   // R9 auipc
        ref_imem[7]  = e_u(20'h80000, 5'd14);                   // R9 negative
        ref_imem[8]  = e_b(13'd12, 5'd13, 5'd1);                // R7 forward taken
        ref_imem[9]  = e_i(12'd1, 5'd0, 3'b000, 5'd21);
        ref_imem[10] = e_i(12'd2, 5'd0, 3'b000, 5'd22);
        ref_imem[11] = e_j(21'd12, 5'd12);
        ref_imem[12] = e_i(12'd7, 5'd0, 3'b000, 5'd23);
        ref_imem[13] = e_j(21'd0, 5'd0);
        ref_imem[14] = e_j(21'h1FFFF8, 5'd15);                  // R8 backward
        run_prog(20, 2, 5);

        finish_up();
    end

endmodule